// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block is the control core of a single-master I2C peripheral. It sits between a register file and two bit-level engines: a clock engine that produces START, STOP and SCL timing, and a data engine that shifts bytes on SDA and samples the acknowledge bit. The register file sends it the request bits (enable, start request, stop request, acknowledge enable) and single-cycle pulses for each CPU access: a read of status word 1, a read of status word 2, a write of the data register and a read of the data register. The sequencer answers with command levels to the engines and with event flags that a polling driver reads back.

The flags are set and cleared by a fixed order of CPU accesses, not by a go/done handshake. The start-generated flag clears when the CPU reads status word 1 and then writes the address byte. The address-done flag clears when the CPU reads status word 1 and then status word 2. The receive-full flag clears when the CPU reads the data register. The address byte's bit `RW_POS` chooses the direction: 1 means read and 0 means write. After an address or data byte, a NACK parks the machine until the driver asks for STOP.

States: `SQ_IDLE`, `SQ_START` (START being generated), `SQ_SB_WAIT` (waiting for the address write), `SQ_ADDR` (address byte on the bus), `SQ_ADDR_WAIT` (waiting for the status 1/status 2 reads), `SQ_TX_WAIT` (data register empty, SCL held), `SQ_TX_BYTE`, `SQ_RX_BYTE`, `SQ_RX_WAIT` (received byte waiting to be read), `SQ_FAIL_HOLD` (after a NACK) and `SQ_STOP`. Transitions: IDLE→START on a start request. START→SB_WAIT on start done. SB_WAIT→ADDR on an ordered address write. ADDR→ADDR_WAIT on ACK, and ADDR→FAIL_HOLD on NACK. ADDR_WAIT→TX_WAIT or →RX_BYTE on the ordered status reads, according to direction. TX_WAIT→TX_BYTE on a data write. TX_WAIT→STOP on a stop request. TX_BYTE→TX_WAIT on ACK, and TX_BYTE→FAIL_HOLD on NACK. RX_BYTE→RX_WAIT when the byte is loaded. RX_WAIT→RX_BYTE or →STOP on a data read. FAIL_HOLD→STOP on a stop request. STOP→IDLE on stop done. Any state goes to IDLE when enable is low.

Top module: `i2cseq_ctrl`

## Requirements
- R1: After reset every output is 0. In idle with `en`=1 and `go_start`=1, `cmd_start` is 1 from the next cycle until `start_done` is seen.
- R2: The cycle after `start_done` in the START state, `ev_started` is 1 and `done_go_start` pulses high for exactly one cycle.
- R3: `ev_started` clears only on a `wr_data` pulse with an earlier `rd_stat1` pulse that no `rd_stat2` or `wr_data` pulse has yet consumed. That write puts the address on the bus (`cmd_tx`=1) and sets `st_transmit` to the inverse of `wdata[RW_POS]`. A write without the earlier read has no effect.
- R4: An ACK (`ack_in`) on the address sets `ev_addr_done`. It clears only on `rd_stat2` after an unconsumed `rd_stat1`. `rd_stat2` on its own leaves it set.
- R5: A NACK (`nack_in`) on an address or data byte sets `ev_ack_fail` and drops every transfer command. The machine then ignores `go_start` until STOP has finished. `ev_ack_fail` stays set until the next START is accepted or `en` falls.
- R6: When the address flag clears in write direction, `ev_tx_empty` is set. A `wr_data` clears `ev_tx_empty` and `ev_byte_done` and asserts `cmd_tx`. An ACK of the data byte sets both flags again.
- R7: When the address flag clears in read direction, `cmd_rx` is asserted. `rx_loaded` sets `ev_rx_full` and ends `cmd_rx`. `rd_data` clears `ev_rx_full` and starts the next byte, unless `go_stop` is 1.
- R8: While a byte is received, `cmd_ack` equals `ack_en` and `cmd_nack` equals its inverse. Outside that time both are 0.
- R9: `go_stop` is taken in the transmit wait, in the failure hold, or on the data read in the receive wait. `cmd_stop` then stays high until `stop_done`. `done_go_stop` pulses one cycle after `stop_done` and never before it. The machine then returns to idle, and every flag except `ev_ack_fail` is cleared.
- R10: `st_master` is 1 in every non-idle state. `st_busy` is 1 from START completion until STOP completion. `st_transmit` is 0 in idle.
- R11: `cmd_hold_scl` is 1 exactly while the machine waits in transmit with the data register empty.
- R12: With `en`=0, on the next cycle the machine is idle and every flag, command and status bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Peripheral enable |
| go_start | input | 1 | Start request bit |
| go_stop | input | 1 | Stop request bit |
| ack_en | input | 1 | Acknowledge received bytes |
| rd_stat1 | input | 1 | CPU read of status word 1 (pulse) |
| rd_stat2 | input | 1 | CPU read of status word 2 (pulse) |
| wr_data | input | 1 | CPU write of data register (pulse) |
| rd_data | input | 1 | CPU read of data register (pulse) |
| wdata | input | DATA_W | Value written with `wr_data` |
| start_done | input | 1 | Clock engine finished START |
| stop_done | input | 1 | Clock engine finished STOP |
| ack_in | input | 1 | Data engine sampled ACK |
| nack_in | input | 1 | Data engine sampled NACK |
| rx_loaded | input | 1 | Received byte placed in data register |
| cmd_start | output | 1 | Generate START |
| cmd_stop | output | 1 | Generate STOP |
| cmd_tx | output | 1 | Transmit one byte |
| cmd_rx | output | 1 | Receive one byte |
| cmd_ack | output | 1 | Answer received byte with ACK |
| cmd_nack | output | 1 | Answer received byte with NACK |
| cmd_hold_scl | output | 1 | Hold SCL low (master stretch) |
| done_go_start | output | 1 | Clear start request bit (pulse) |
| done_go_stop | output | 1 | Clear stop request bit (pulse) |
| ev_started | output | 1 | START generated flag |
| ev_addr_done | output | 1 | Address acknowledged flag |
| ev_tx_empty | output | 1 | Data register empty flag |
| ev_byte_done | output | 1 | Byte transfer finished flag |
| ev_ack_fail | output | 1 | Acknowledge failure flag |
| ev_rx_full | output | 1 | Received byte waiting flag |
| st_master | output | 1 | Master mode |
| st_busy | output | 1 | Bus busy |
| st_transmit | output | 1 | Transmitter direction |

## Verification
The hardest cases to reach are the ordering rules. A data write or a status-2 read that arrives without an unconsumed status-1 read must leave the flags untouched, and a start request that arrives during the failure hold must be ignored. The stimulus sends these out-of-order accesses on purpose, each just before the correct sequence, and checks that the flag survives. It then ends one transaction with a NACK on the address and another with a NACK on a data byte, so that the acknowledge-failure flag is shown to persist through STOP and to clear on the next accepted START.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_START,
        SQ_SB_WAIT,
        SQ_ADDR,
        SQ_ADDR_WAIT,
        SQ_TX_WAIT,
        SQ_TX_BYTE,
        SQ_RX_BYTE,
        SQ_RX_WAIT,
        SQ_FAIL_HOLD,
        SQ_STOP
    } seq_state_t;

    typedef struct packed {
        logic ack_fail;
        logic rx_full;
        logic byte_done;
        logic tx_empty;
        logic addr_done;
        logic started;
    } evt_flags_t;

    localparam int EVT_N = $bits(evt_flags_t);

endpackage

// File: rtl/i2cseq_access_track.sv
// Remembers a status-1 read until a status-2 read or a data write uses it up.
module i2cseq_access_track (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rd_stat1,
    input  logic rd_stat2,
    input  logic wr_data,
    output logic stat1_seen
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  stat1_seen <= 1'b0;
        else if (!en)                stat1_seen <= 1'b0;
        else if (rd_stat1)           stat1_seen <= 1'b1;
        else if (rd_stat2 | wr_data) stat1_seen <= 1'b0;
    end

endmodule

// File: rtl/i2cseq_flags.sv
// Event flag bank: set wins over clear, disable wipes every bit.
module i2cseq_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (!en)      bit_q <= 1'b0;
            else if (set_v[i]) bit_q <= 1'b1;
            else if (clr_v[i]) bit_q <= 1'b0;
        end
        assign q[i] = bit_q;
    end

endmodule

// File: rtl/i2cseq_fsm.sv
module i2cseq_fsm
    import i2cseq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RW_POS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              go_start,
    input  logic              go_stop,
    input  logic              ack_en,
    input  logic              stat1_seen,
    input  logic              rd_stat2,
    input  logic              wr_data,
    input  logic              rd_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              start_done,
    input  logic              stop_done,
    input  logic              ack_in,
    input  logic              nack_in,
    input  logic              rx_loaded,
    output evt_flags_t        set_f,
    output evt_flags_t        clr_f,
    output logic              transmit,
    output logic              done_go_start,
    output logic              done_go_stop,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_tx,
    output logic              cmd_rx,
    output logic              cmd_ack,
    output logic              cmd_nack,
    output logic              cmd_hold_scl,
    output logic              master,
    output logic              busy
);

    seq_state_t cur, nxt;
    logic       tra_nxt;
    logic       pulse_start, pulse_stop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur           <= SQ_IDLE;
            transmit      <= 1'b0;
            done_go_start <= 1'b0;
            done_go_stop  <= 1'b0;
        end else begin
            cur           <= nxt;
            transmit      <= tra_nxt;
            done_go_start <= pulse_start;
            done_go_stop  <= pulse_stop;
        end
    end

    // transitions and flag events
    always_comb begin
        nxt         = cur;
        tra_nxt     = transmit;
        set_f       = '0;
        clr_f       = '0;
        pulse_start = 1'b0;
        pulse_stop  = 1'b0;
        unique case (cur)
            SQ_IDLE: begin
                if (go_start) begin
                    nxt            = SQ_START;
                    clr_f.ack_fail = 1'b1;
                end
            end
            SQ_START: begin
                if (start_done) begin
                    nxt           = SQ_SB_WAIT;
                    set_f.started = 1'b1;
                    pulse_start   = 1'b1;
                end
            end
            SQ_SB_WAIT: begin
                if (wr_data && stat1_seen) begin
                    nxt           = SQ_ADDR;
                    clr_f.started = 1'b1;
                    tra_nxt       = ~wdata[RW_POS];
                end
            end
            SQ_ADDR: begin
                if (nack_in) begin
                    nxt            = SQ_FAIL_HOLD;
                    set_f.ack_fail = 1'b1;
                end else if (ack_in) begin
                    nxt             = SQ_ADDR_WAIT;
                    set_f.addr_done = 1'b1;
                end
            end
            SQ_ADDR_WAIT: begin
                if (rd_stat2 && stat1_seen) begin
                    clr_f.addr_done = 1'b1;
                    if (transmit) begin
                        nxt            = SQ_TX_WAIT;
                        set_f.tx_empty = 1'b1;
                    end else begin
                        nxt = SQ_RX_BYTE;
                    end
                end
            end
            SQ_TX_WAIT: begin
                if (go_stop) begin
                    nxt = SQ_STOP;
                end else if (wr_data) begin
                    nxt             = SQ_TX_BYTE;
                    clr_f.tx_empty  = 1'b1;
                    clr_f.byte_done = 1'b1;
                end
            end
            SQ_TX_BYTE: begin
                if (nack_in) begin
                    nxt            = SQ_FAIL_HOLD;
                    set_f.ack_fail = 1'b1;
                end else if (ack_in) begin
                    nxt             = SQ_TX_WAIT;
                    set_f.tx_empty  = 1'b1;
                    set_f.byte_done = 1'b1;
                end
            end
            SQ_RX_BYTE: begin
                if (rx_loaded) begin
                    nxt           = SQ_RX_WAIT;
                    set_f.rx_full = 1'b1;
                end
            end
            SQ_RX_WAIT: begin
                if (rd_data) begin
                    clr_f.rx_full = 1'b1;
                    nxt           = go_stop ? SQ_STOP : SQ_RX_BYTE;
                end
            end
            SQ_FAIL_HOLD: begin
                if (go_stop) nxt = SQ_STOP;
            end
            SQ_STOP: begin
                if (stop_done) begin
                    nxt             = SQ_IDLE;
                    pulse_stop      = 1'b1;
                    tra_nxt         = 1'b0;
                    clr_f.started   = 1'b1;
                    clr_f.addr_done = 1'b1;
                    clr_f.tx_empty  = 1'b1;
                    clr_f.byte_done = 1'b1;
                    clr_f.rx_full   = 1'b1;
                end
            end
            default: nxt = SQ_IDLE;
        endcase
        if (!en) begin
            nxt         = SQ_IDLE;
            tra_nxt     = 1'b0;
            set_f       = '0;
            clr_f       = '0;
            pulse_start = 1'b0;
            pulse_stop  = 1'b0;
        end
    end

    // command and status outputs
    always_comb begin
        cmd_start    = (cur == SQ_START);
        cmd_stop     = (cur == SQ_STOP);
        cmd_tx       = (cur == SQ_ADDR) || (cur == SQ_TX_BYTE);
        cmd_rx       = (cur == SQ_RX_BYTE);
        cmd_ack      = cmd_rx & ack_en;
        cmd_nack     = cmd_rx & ~ack_en;
        cmd_hold_scl = (cur == SQ_TX_WAIT);
        master       = (cur != SQ_IDLE);
        busy         = (cur != SQ_IDLE) && (cur != SQ_START);
    end

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
    import i2cseq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RW_POS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              go_start,
    input  logic              go_stop,
    input  logic              ack_en,
    input  logic              rd_stat1,
    input  logic              rd_stat2,
    input  logic              wr_data,
    input  logic              rd_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              start_done,
    input  logic              stop_done,
    input  logic              ack_in,
    input  logic              nack_in,
    input  logic              rx_loaded,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_tx,
    output logic              cmd_rx,
    output logic              cmd_ack,
    output logic              cmd_nack,
    output logic              cmd_hold_scl,
    output logic              done_go_start,
    output logic              done_go_stop,
    output logic              ev_started,
    output logic              ev_addr_done,
    output logic              ev_tx_empty,
    output logic              ev_byte_done,
    output logic              ev_ack_fail,
    output logic              ev_rx_full,
    output logic              st_master,
    output logic              st_busy,
    output logic              st_transmit
);

    logic             stat1_seen;
    evt_flags_t       set_f, clr_f, flags;
    logic [EVT_N-1:0] flag_q;

    i2cseq_access_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .rd_stat1   (rd_stat1),
        .rd_stat2   (rd_stat2),
        .wr_data    (wr_data),
        .stat1_seen (stat1_seen)
    );

    i2cseq_fsm #(.DATA_W(DATA_W), .RW_POS(RW_POS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .go_start      (go_start),
        .go_stop       (go_stop),
        .ack_en        (ack_en),
        .stat1_seen    (stat1_seen),
        .rd_stat2      (rd_stat2),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .wdata         (wdata),
        .start_done    (start_done),
        .stop_done     (stop_done),
        .ack_in        (ack_in),
        .nack_in       (nack_in),
        .rx_loaded     (rx_loaded),
        .set_f         (set_f),
        .clr_f         (clr_f),
        .transmit      (st_transmit),
        .done_go_start (done_go_start),
        .done_go_stop  (done_go_stop),
        .cmd_start     (cmd_start),
        .cmd_stop      (cmd_stop),
        .cmd_tx        (cmd_tx),
        .cmd_rx        (cmd_rx),
        .cmd_ack       (cmd_ack),
        .cmd_nack      (cmd_nack),
        .cmd_hold_scl  (cmd_hold_scl),
        .master        (st_master),
        .busy          (st_busy)
    );

    i2cseq_flags #(.N(EVT_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .set_v (set_f),
        .clr_v (clr_f),
        .q     (flag_q)
    );

    assign flags        = evt_flags_t'(flag_q);
    assign ev_started   = flags.started;
    assign ev_addr_done = flags.addr_done;
    assign ev_tx_empty  = flags.tx_empty;
    assign ev_byte_done = flags.byte_done;
    assign ev_ack_fail  = flags.ack_fail;
    assign ev_rx_full   = flags.rx_full;

    // at most one bus command at a time (R3, R7, R9)
    p_one_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_start, cmd_stop, cmd_tx, cmd_rx}));

    // start-request clear coincides with the started flag (R2)
    p_started_with_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_go_start |-> ev_started);

    // address flag falls only after a status-2 read while enabled (R4)
    p_addr_clear_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ev_addr_done) && $past(en)) |-> $past(rd_stat2));

    // ACK and NACK requests never together (R8)
    p_ack_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ack && cmd_nack));

    // stop-request clear only after stop completion (R9)
    p_stop_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_go_stop |-> $past(stop_done));

    // busy implies master (R10)
    p_busy_master_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_busy |-> st_master);

    // SCL held only while the data register is empty (R11)
    p_hold_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hold_scl |-> ev_tx_empty);

    // disable wipes everything (R12)
    p_disable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (flag_q == '0 && !st_master && !st_transmit));

endmodule

// File: tb/i2cseq_ctrl_test.sv
module i2cseq_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, go_start = 1'b0, go_stop = 1'b0, ack_en = 1'b1;
    logic rd_stat1 = 1'b0, rd_stat2 = 1'b0, wr_data = 1'b0, rd_data = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic start_done = 1'b0, stop_done = 1'b0, ack_in = 1'b0, nack_in = 1'b0, rx_loaded = 1'b0;
    logic cmd_start, cmd_stop, cmd_tx, cmd_rx, cmd_ack, cmd_nack, cmd_hold_scl;
    logic done_go_start, done_go_stop;
    logic ev_started, ev_addr_done, ev_tx_empty, ev_byte_done, ev_ack_fail, ev_rx_full;
    logic st_master, st_busy, st_transmit;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    i2cseq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .en(en), .go_start(go_start), .go_stop(go_stop),
        .ack_en(ack_en), .rd_stat1(rd_stat1), .rd_stat2(rd_stat2), .wr_data(wr_data),
        .rd_data(rd_data), .wdata(wdata), .start_done(start_done), .stop_done(stop_done),
        .ack_in(ack_in), .nack_in(nack_in), .rx_loaded(rx_loaded),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_tx(cmd_tx), .cmd_rx(cmd_rx),
        .cmd_ack(cmd_ack), .cmd_nack(cmd_nack), .cmd_hold_scl(cmd_hold_scl),
        .done_go_start(done_go_start), .done_go_stop(done_go_stop),
        .ev_started(ev_started), .ev_addr_done(ev_addr_done), .ev_tx_empty(ev_tx_empty),
        .ev_byte_done(ev_byte_done), .ev_ack_fail(ev_ack_fail), .ev_rx_full(ev_rx_full),
        .st_master(st_master), .st_busy(st_busy), .st_transmit(st_transmit)
    );

    // ---------------- reference model ----------------
    localparam int P_IDLE = 0, P_START = 1, P_SBW = 2, P_ADR = 3, P_ADW = 4, P_TXW = 5,
                   P_TXB = 6, P_RXB = 7, P_RXW = 8, P_FAIL = 9, P_STOP = 10;
    int phase = P_IDLE;
    bit m_sb, m_ad, m_txe, m_btf, m_af, m_rxf, m_tra, m_seen, m_cs, m_cp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase = P_IDLE;
            {m_sb, m_ad, m_txe, m_btf, m_af, m_rxf, m_tra, m_seen, m_cs, m_cp} = '0;
        end else if (!en) begin
            phase = P_IDLE;
            {m_sb, m_ad, m_txe, m_btf, m_af, m_rxf, m_tra, m_seen, m_cs, m_cp} = '0;
        end else begin
            m_cs = 1'b0;
            m_cp = 1'b0;
            case (phase)
                P_IDLE:  if (go_start) begin phase = P_START; m_af = 1'b0; end
                P_START: if (start_done) begin phase = P_SBW; m_sb = 1'b1; m_cs = 1'b1; end
                P_SBW:   if (wr_data && m_seen) begin phase = P_ADR; m_sb = 1'b0; m_tra = !wdata[0]; end
                P_ADR:   if (nack_in) begin phase = P_FAIL; m_af = 1'b1; end
                         else if (ack_in) begin phase = P_ADW; m_ad = 1'b1; end
                P_ADW:   if (rd_stat2 && m_seen) begin
                             m_ad = 1'b0;
                             if (m_tra) begin phase = P_TXW; m_txe = 1'b1; end
                             else phase = P_RXB;
                         end
                P_TXW:   if (go_stop) phase = P_STOP;
                         else if (wr_data) begin phase = P_TXB; m_txe = 1'b0; m_btf = 1'b0; end
                P_TXB:   if (nack_in) begin phase = P_FAIL; m_af = 1'b1; end
                         else if (ack_in) begin phase = P_TXW; m_txe = 1'b1; m_btf = 1'b1; end
                P_RXB:   if (rx_loaded) begin phase = P_RXW; m_rxf = 1'b1; end
                P_RXW:   if (rd_data) begin m_rxf = 1'b0; phase = go_stop ? P_STOP : P_RXB; end
                P_FAIL:  if (go_stop) phase = P_STOP;
                P_STOP:  if (stop_done) begin
                             phase = P_IDLE; m_cp = 1'b1; m_tra = 1'b0;
                             {m_sb, m_ad, m_txe, m_btf, m_rxf} = '0;
                         end
                default: phase = P_IDLE;
            endcase
            if (rd_stat1) m_seen = 1'b1;
            else if (rd_stat2 || wr_data) m_seen = 1'b0;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, 2 ns after the active edge
    always begin
        @(posedge clk);
        #2;
        if (!finished) begin
            chk(cmd_start,     phase == P_START,                   "R1 cmd_start");
            chk(done_go_start, m_cs,                               "R2 done_go_start");
            chk(ev_started,    m_sb,                               "R2 ev_started");
            chk(cmd_tx,        phase == P_ADR || phase == P_TXB,   "R3 cmd_tx");
            chk(ev_addr_done,  m_ad,                               "R4 ev_addr_done");
            chk(ev_ack_fail,   m_af,                               "R5 ev_ack_fail");
            chk(ev_tx_empty,   m_txe,                              "R6 ev_tx_empty");
            chk(ev_byte_done,  m_btf,                              "R6 ev_byte_done");
            chk(cmd_rx,        phase == P_RXB,                     "R7 cmd_rx");
            chk(ev_rx_full,    m_rxf,                              "R7 ev_rx_full");
            chk(cmd_ack,       phase == P_RXB && ack_en,           "R8 cmd_ack");
            chk(cmd_nack,      phase == P_RXB && !ack_en,          "R8 cmd_nack");
            chk(cmd_stop,      phase == P_STOP,                    "R9 cmd_stop");
            chk(done_go_stop,  m_cp,                               "R9 done_go_stop");
            chk(st_master,     phase != P_IDLE,                    "R10 st_master");
            chk(st_busy,       phase != P_IDLE && phase != P_START, "R10 st_busy");
            chk(st_transmit,   m_tra,                              "R10 st_transmit");
            chk(cmd_hold_scl,  phase == P_TXW,                     "R11 cmd_hold_scl");
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            failures++;
            finished = 1'b1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // START, ordered status-1 read and address write; leaves address on the bus
    task automatic open_addr(input logic [7:0] a);
        go_start = 1'b1; step(2);
        start_done = 1'b1; step(1); start_done = 1'b0; go_start = 1'b0;
        rd_stat1 = 1'b1; step(1); rd_stat1 = 1'b0;
        wdata = a; wr_data = 1'b1; step(1); wr_data = 1'b0;
        step(2);
    endtask

    task automatic addr_ack_and_clear();
        ack_in = 1'b1; step(1); ack_in = 1'b0;
        rd_stat1 = 1'b1; step(1); rd_stat1 = 1'b0;
        rd_stat2 = 1'b1; step(1); rd_stat2 = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        wdata = b; wr_data = 1'b1; step(1); wr_data = 1'b0;
        step(3); ack_in = 1'b1; step(1); ack_in = 1'b0;
    endtask

    task automatic finish_stop();
        go_stop = 1'b1; step(3);
        stop_done = 1'b1; step(1); stop_done = 1'b0; go_stop = 1'b0;
        step(1);
    endtask

    // ---------------- directed scenarios ----------------
    initial begin
        step(3);
        chk(st_master, 1'b0, "R1 reset master");
        chk(ev_tx_empty, 1'b0, "R1 reset flag");
        rst_n = 1'b1;
        step(2);

        // write transaction with out-of-order accesses first
        go_start = 1'b1; step(1);
        chk(cmd_start, 1'b1, "R1 start cmd");
        chk(st_busy, 1'b0, "R10 busy before start done");
        step(2);
        start_done = 1'b1; step(1); start_done = 1'b0;
        chk(ev_started, 1'b1, "R2 started set");
        chk(done_go_start, 1'b1, "R2 clear pulse");
        go_start = 1'b0; step(1);
        chk(done_go_start, 1'b0, "R2 single pulse");
        wdata = 8'hA0; wr_data = 1'b1; step(1); wr_data = 1'b0;
        chk(ev_started, 1'b1, "R3 write without status read ignored");
        chk(cmd_tx, 1'b0, "R3 no address launch");
        rd_stat1 = 1'b1; step(1); rd_stat1 = 1'b0;
        wr_data = 1'b1; step(1); wr_data = 1'b0;
        chk(ev_started, 1'b0, "R3 started cleared");
        chk(cmd_tx, 1'b1, "R3 address launched");
        chk(st_transmit, 1'b1, "R3 write direction");
        step(3);
        ack_in = 1'b1; step(1); ack_in = 1'b0;
        chk(ev_addr_done, 1'b1, "R4 address flag");
        rd_stat2 = 1'b1; step(1); rd_stat2 = 1'b0;
        chk(ev_addr_done, 1'b1, "R4 status-2 alone ignored");
        rd_stat1 = 1'b1; step(1); rd_stat1 = 1'b0;
        rd_stat2 = 1'b1; step(1); rd_stat2 = 1'b0;
        chk(ev_addr_done, 1'b0, "R4 address flag cleared");
        chk(ev_tx_empty, 1'b1, "R6 empty after address");
        chk(cmd_hold_scl, 1'b1, "R11 hold while empty");
        step(3);
        chk(cmd_hold_scl, 1'b1, "R11 hold persists");
        wdata = 8'h55; wr_data = 1'b1; step(1); wr_data = 1'b0;
        chk(ev_tx_empty, 1'b0, "R6 empty cleared");
        chk(cmd_hold_scl, 1'b0, "R11 released on write");
        step(3); ack_in = 1'b1; step(1); ack_in = 1'b0;
        chk(ev_byte_done, 1'b1, "R6 byte done");
        send_byte(8'h3C);
        go_stop = 1'b1; step(1);
        chk(cmd_stop, 1'b1, "R9 stop taken in tx wait");
        step(2);
        chk(done_go_stop, 1'b0, "R9 no early clear");
        stop_done = 1'b1; step(1); stop_done = 1'b0;
        chk(done_go_stop, 1'b1, "R9 clear after done");
        chk(st_master, 1'b0, "R10 idle after stop");
        chk(ev_tx_empty, 1'b0, "R9 flags wiped");
        go_stop = 1'b0; step(2);

        // read transaction, ACK then NACK
        ack_en = 1'b1;
        open_addr(8'hA1);
        chk(st_transmit, 1'b0, "R3 read direction");
        addr_ack_and_clear();
        chk(cmd_rx, 1'b1, "R7 receive started");
        chk(cmd_ack, 1'b1, "R8 ack requested");
        step(6); rx_loaded = 1'b1; step(1); rx_loaded = 1'b0;
        chk(ev_rx_full, 1'b1, "R7 rx full");
        chk(cmd_ack, 1'b0, "R8 ack idle after byte");
        step(2);
        rd_data = 1'b1; step(1); rd_data = 1'b0;
        chk(ev_rx_full, 1'b0, "R7 rx full cleared");
        chk(cmd_rx, 1'b1, "R7 next byte");
        ack_en = 1'b0; step(1);
        chk(cmd_nack, 1'b1, "R8 nack requested");
        step(4); rx_loaded = 1'b1; step(1); rx_loaded = 1'b0;
        go_stop = 1'b1; step(2);
        chk(cmd_stop, 1'b0, "R9 stop waits for data read");
        rd_data = 1'b1; step(1); rd_data = 1'b0;
        chk(cmd_stop, 1'b1, "R9 stop after read");
        step(2); stop_done = 1'b1; step(1); stop_done = 1'b0; go_stop = 1'b0;
        step(2);

        // NACK on address
        open_addr(8'h90);
        nack_in = 1'b1; step(1); nack_in = 1'b0;
        chk(ev_ack_fail, 1'b1, "R5 address nack");
        chk(cmd_tx, 1'b0, "R5 transfer dropped");
        go_start = 1'b1; step(2);
        chk(cmd_start, 1'b0, "R5 start ignored in hold");
        go_start = 1'b0;
        finish_stop();
        chk(ev_ack_fail, 1'b1, "R5 fail survives stop");
        go_start = 1'b1; step(1);
        chk(ev_ack_fail, 1'b0, "R5 fail cleared by start");
        go_start = 1'b0;
        step(1); start_done = 1'b1; step(1); start_done = 1'b0;
        rd_stat1 = 1'b1; step(1); rd_stat1 = 1'b0;
        wdata = 8'h90; wr_data = 1'b1; step(1); wr_data = 1'b0;
        step(1);
        addr_ack_and_clear();
        wdata = 8'h11; wr_data = 1'b1; step(1); wr_data = 1'b0;
        step(2); nack_in = 1'b1; step(1); nack_in = 1'b0;
        chk(ev_ack_fail, 1'b1, "R5 data nack");
        finish_stop();

        // disable in the middle of a transmit
        open_addr(8'hB0);
        addr_ack_and_clear();
        chk(cmd_hold_scl, 1'b1, "R11 hold before disable");
        en = 1'b0; step(1);
        chk(st_master, 1'b0, "R12 idle on disable");
        chk(ev_tx_empty, 1'b0, "R12 flags cleared");
        chk(cmd_hold_scl, 1'b0, "R12 hold released");
        chk(st_transmit, 1'b0, "R12 direction cleared");
        step(2);
        en = 1'b1; step(3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule